// File: doc/BRIEF.md
# Add-Then-Shift Single-Step Shifter

This block is one datapath step for a microcoded processor. It adds two 16-bit operands and shifts the sum by exactly one bit position. The carry out of the addition is dropped before the shift. A one-bit direction code from the microinstruction picks a left or a right shift. Two control bits taken from the current instruction word pick how the vacated bit is filled. The choices are a rotate, a zero fill, or a sign-preserving fill.

A microsequencer raises the enable strobe for one clock per microinstruction that uses this step. The shifted sum is captured in an output register. A valid flag marks the cycle in which that result can be used. When enable is low the register keeps its last value, and the operand and control inputs have no effect.

Top module: `ats_shifter`

## Requirements
- R1: After reset, `result` is 0 and `resultValid` is 0.
- R2: `resultValid` is 1 in exactly the cycle after a clock edge at which `enable` was 1, and 0 after any edge at which `enable` was 0. Each enabled edge produces exactly one valid result.
- R3: The value that is shifted is `(opR + opS) mod 2^16`, so the carry out of bit 15 never reaches the result.
- R4: When `irCtl[1]` is 1 (instruction bit 7 set), the shift is a rotate whatever the value of `irCtl[0]`. A left rotate moves bit 15 into bit 0, and a right rotate moves bit 0 into bit 15.
- R5: When `irCtl` is 2'b01, the shift is a zero-fill shift: bit 0 is cleared on a left shift and bit 15 is cleared on a right shift.
- R6: When `irCtl` is 2'b00 and the shift is to the right, bit 15 of the result is a copy of bit 15 of the sum.
- R7: When `irCtl` is 2'b00 and the shift is to the left, bit 15 of the result equals bit 15 of the sum, bits 14..1 take sum bits 13..0, and bit 0 is 0.
- R8: While `enable` is 0, `result` holds its value whatever `opR`, `opS`, `dirCode` and `irCtl` do.
- R9: `dirCode` = 1 selects a left shift (toward bit 15) and `dirCode` = 0 selects a right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | One-cycle strobe that requests an add-and-shift step |
| opR | input | 16 | First addend |
| opS | input | 16 | Second addend |
| dirCode | input | 1 | Shift direction: 1 left, 0 right |
| irCtl | input | 2 | Instruction bits 7 and 8; [1] is bit 7, [0] is bit 8 |
| result | output | 16 | Registered shifted sum |
| resultValid | output | 1 | Result produced by the previous clock edge |

## Verification
Each result is due one rising edge after the edge that samples `enable`. The bench drives inputs on falling edges, so a step issued at one falling edge is compared at the next falling edge. The monitor pops one expected item from its queue for each falling edge at which `resultValid` is high. Any valid flag with nothing queued, or any item left in the queue at the end, is counted as an R2 failure. Hold checks leave `enable` low, scramble the other inputs across one full rising edge, and then compare `result` with the last value popped.

// File: rtl/ats_pkg.sv
package ats_pkg;

  typedef enum logic [1:0] {
    SHK_ARITH = 2'd0,
    SHK_LOGIC = 2'd1,
    SHK_CIRC  = 2'd2
  } shiftKind_e;

  typedef struct packed {
    logic       load;
    logic       toLeft;
    shiftKind_e kind;
  } atsStrobe_t;

endpackage

// File: rtl/ats_ctrl.sv
module ats_ctrl
  import ats_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dirCode,
  input  logic [1:0] irCtl,
  output atsStrobe_t strobe,
  output logic       validQ
);

  shiftKind_e kindSel;

  // Bit 7 of the instruction dominates; bit 8 only matters when bit 7 is clear.
  always_comb begin
    if (irCtl[1])      kindSel = SHK_CIRC;
    else if (irCtl[0]) kindSel = SHK_LOGIC;
    else               kindSel = SHK_ARITH;
  end

  always_comb begin
    strobe.load   = enable;
    strobe.toLeft = dirCode;
    strobe.kind   = kindSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= enable;
  end

endmodule

// File: rtl/ats_datapath.sv
module ats_datapath
  import ats_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  atsStrobe_t       strobe,
  input  logic [WIDTH-1:0] opR,
  input  logic [WIDTH-1:0] opS,
  output logic [WIDTH-1:0] resultQ
);

  localparam int MSB = WIDTH - 1;

  logic [MSB:0] sum;
  logic [MSB:0] leftVal;
  logic [MSB:0] rightVal;
  logic [MSB:0] shifted;
  logic         fillLsb;
  logic         fillMsb;
  logic         keepSign;

  // The sum has the operand width, so the carry out is discarded here.
  assign sum = opR + opS;

  always_comb begin
    keepSign = (strobe.kind == SHK_ARITH);
    fillLsb  = (strobe.kind == SHK_CIRC) ? sum[MSB] : 1'b0;
    case (strobe.kind)
      SHK_CIRC:  fillMsb = sum[0];
      SHK_ARITH: fillMsb = sum[MSB];
      default:   fillMsb = 1'b0;
    endcase
  end

  for (genvar i = 0; i <= MSB; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign leftVal[i]  = fillLsb;
      assign rightVal[i] = sum[i+1];
    end else if (i == MSB) begin : g_msb
      assign leftVal[i]  = keepSign ? sum[MSB] : sum[MSB-1];
      assign rightVal[i] = fillMsb;
    end else begin : g_mid
      assign leftVal[i]  = sum[i-1];
      assign rightVal[i] = sum[i+1];
    end
  end

  assign shifted = strobe.toLeft ? leftVal : rightVal;

  always_ff @(posedge clk) begin
    if (!rstN)            resultQ <= '0;
    else if (strobe.load) resultQ <= shifted;
  end

endmodule

// File: rtl/ats_shifter.sv
module ats_shifter
  import ats_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [WIDTH-1:0] opR,
  input  logic [WIDTH-1:0] opS,
  input  logic             dirCode,
  input  logic [1:0]       irCtl,
  output logic [WIDTH-1:0] result,
  output logic             resultValid
);

  atsStrobe_t strobe;

  ats_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .dirCode (dirCode),
    .irCtl   (irCtl),
    .strobe  (strobe),
    .validQ  (resultValid)
  );

  ats_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opR     (opR),
    .opS     (opS),
    .resultQ (result)
  );

endmodule

// File: rtl/ats_shifter_chk.sv
module ats_shifter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [WIDTH-1:0] opR,
  input logic [WIDTH-1:0] opS,
  input logic             dirCode,
  input logic [1:0]       irCtl,
  input logic [WIDTH-1:0] result,
  input logic             resultValid
);

  logic [WIDTH-1:0] sumChk;
  assign sumChk = opR + opS;

  p_valid_after_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> resultValid);

  p_valid_low_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !resultValid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(result));

  p_rotate_keeps_ones_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && irCtl[1]) |=> ($countones(result) == $countones($past(sumChk))));

  p_zero_fill_right_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && irCtl == 2'b01 && !dirCode) |=> !result[WIDTH-1]);

  p_zero_fill_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && irCtl == 2'b01 && dirCode) |=> !result[0]);

  p_sign_copy_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && irCtl == 2'b00 && !dirCode) |=> (result[WIDTH-1] == $past(sumChk[WIDTH-1])));

  p_sign_keep_left_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && irCtl == 2'b00 && dirCode) |=>
      (result[WIDTH-1] == $past(sumChk[WIDTH-1]) && !result[0]));

endmodule

bind ats_shifter ats_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .opR         (opR),
  .opS         (opS),
  .dirCode     (dirCode),
  .irCtl       (irCtl),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/test_ats_shifter.sv
module test_ats_shifter;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] opR = '0;
  logic [15:0] opS = '0;
  logic        dirCode = 1'b0;
  logic [1:0]  irCtl = 2'b00;
  logic [15:0] result;
  logic        resultValid;

  int          nRun = 0;
  int          nFail = 0;
  expItem_t    expQ[$];
  logic [15:0] lastSeen = '0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ats_shifter i_ats_shifter (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .opR         (opR),
    .opS         (opS),
    .dirCode     (dirCode),
    .irCtl       (irCtl),
    .result      (result),
    .resultValid (resultValid)
  );

  function automatic logic [15:0] model(input logic [15:0] r, input logic [15:0] s,
                                        input logic left, input logic [1:0] ctl);
    int unsigned sm;
    int unsigned res;
    sm = (int'(r) + int'(s)) % 65536;
    if (ctl[1]) begin
      res = left ? (((sm << 1) | (sm >> 15)) & 32'hFFFF)
                 : ((sm >> 1) | ((sm & 1) << 15));
    end else if (ctl[0]) begin
      res = left ? ((sm << 1) & 32'hFFFF) : (sm >> 1);
    end else begin
      res = left ? (((sm << 1) & 32'h7FFF) | (sm & 32'h8000))
                 : ((sm >> 1) | (sm & 32'h8000));
    end
    return res[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] r, input logic [15:0] s, input logic left,
                       input logic [1:0] ctl, input string tag);
    expItem_t it;
    @(negedge clk);
    opR = r; opS = s; dirCode = left; irCtl = ctl; enable = 1'b1;
    it.val = model(r, s, left, ctl);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // R8: idle with scrambled inputs; result must hold and valid must drop.
  task automatic idleHold(input logic [15:0] junk);
    @(negedge clk);
    enable = 1'b0; opR = junk; opS = ~junk; dirCode = junk[0]; irCtl = junk[2:1];
    @(negedge clk);
    check(result == lastSeen, "R8 hold", result, lastSeen);
    check(!resultValid, "R2 valid low when idle", {15'd0, resultValid}, 16'd0);
  endtask

  // Monitor: one expected item per valid cycle.
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (expQ.size() == 0) begin
        nRun++; nFail++;
        $display("FAIL R2 unexpected valid actual=%h expected=none", result);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(result == it.val, it.tag, result, it.val);
        lastSeen = result;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(result == 16'd0, "R1 result after reset", result, 16'd0);
    check(!resultValid, "R1 valid after reset", {15'd0, resultValid}, 16'd0);
    rstN = 1'b1;

    issue(16'h1234, 16'h4321, 1'b1, 2'b10, "R4 R9 rotate left");
    issue(16'h8000, 16'h0001, 1'b1, 2'b11, "R4 rotate left ctl11");
    issue(16'h0003, 16'h0000, 1'b0, 2'b10, "R4 R9 rotate right");
    issue(16'h4001, 16'h0000, 1'b0, 2'b11, "R4 rotate right ctl11");
    idleHold(16'hA5A5);
    issue(16'h8001, 16'h0000, 1'b1, 2'b01, "R5 R9 logical left");
    issue(16'h8001, 16'h0000, 1'b0, 2'b01, "R5 R9 logical right");
    issue(16'h9000, 16'h0F00, 1'b0, 2'b00, "R6 arith right negative");
    issue(16'h3000, 16'h0F01, 1'b0, 2'b00, "R6 arith right positive");
    issue(16'hC001, 16'h0000, 1'b1, 2'b00, "R7 arith left bit14 set");
    issue(16'h4001, 16'h0000, 1'b1, 2'b00, "R7 arith left positive");
    issue(16'h8000, 16'h2001, 1'b1, 2'b00, "R7 arith left negative");
    idleHold(16'h5A3C);
    issue(16'hFFFF, 16'h0001, 1'b1, 2'b10, "R3 carry dropped");
    issue(16'h8000, 16'h8000, 1'b0, 2'b00, "R3 carry dropped arith");
    issue(16'hFFFF, 16'hFFFF, 1'b0, 2'b10, "R3 carry dropped rotate");
    idleHold(16'h0F0F);
    idleHold(16'hF00F);

    lfsr = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a;
      logic [15:0] b;
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(a, b, b[3], a[5:4], "R3 R4 R5 R6 R7 mixed");
      if (k % 7 == 6) idleHold(a ^ b);
    end
    idleHold(16'h1111);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all results produced", 16'(expQ.size()), 16'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule